// File: doc/BRIEF.md
# Control/Status Register Access Check and Read-Modify-Write

This block sits between an instruction's register-access request and the register storage of a processor core. Each cycle it takes one access request: the kind of operation (plain read, swap, set bits, clear bits), a source operand from a register or a 5-bit immediate, the 12-bit register address, and the current privilege level. The old contents of the addressed register arrive on `csr_rdata`. The block turns the operation into a value/mask pair. It then decides whether the access is legal and, when it is, produces the merged write data, a write strobe and the old value to return. Everything is combinational and settles in the same cycle as the request.

Legality comes from two places. The first is the address itself. Bits [9:8] give the lowest privilege that may touch the register. Bits [11:10] equal to 3 mark a read-only register. The second is a set of predicates from the surrounding core: whether the register exists, whether supervisor mode is built in, the floating-point state field, and the two counter-enable words. Any veto blocks the write and zeroes the returned value.

Top module: `csr_access_unit`

## Requirements
- R1: `acc_kind` 0 is a plain read (value 0, mask 0), 1 a swap (value = operand, mask all ones), 2 a set (value all ones, mask = operand), 3 a clear (value 0, mask = operand). With `acc_use_imm` = 1 the operand is `acc_imm` zero-extended, otherwise `acc_src`.
- R2: On a legal access with a nonzero mask, `wr_en` = 1 and `wr_data` = (`csr_rdata` AND NOT mask) OR (value AND mask).
- R3: When the mask is all zero, `wr_en` = 0 even for a writable register. This covers a plain read, and a set or clear with a zero operand.
- R4: The access is illegal when `cur_priv` (user 0, supervisor 1, machine 3) is numerically below `csr_addr[9:8]`.
- R5: When `csr_addr[11:10]` = 3, a nonzero mask makes the access illegal. A zero mask is a legal read.
- R6: Counter addresses 0xC00–0xC1F and 0xC80–0xC9F are gated by bit `csr_addr[4:0]` of `sup_cnt_en` in user mode and of `mach_cnt_en` in supervisor mode. A clear bit makes the access illegal. Machine mode is never gated.
- R7: Addresses 0x001–0x003 are illegal while `fp_state` = 0.
- R8: Addresses with `csr_addr[9:8]` = 1 are illegal while `sup_mode_present` = 0.
- R9: With `csr_present` = 0 the access is illegal.
- R10: When `illegal` = 1, `wr_en` = 0 and `old_value` = 0.
- R11: When `illegal` = 0, `old_value` equals `csr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_kind | input | 2 | Operation: 0 read, 1 swap, 2 set, 3 clear |
| acc_use_imm | input | 1 | Take the operand from `acc_imm` instead of `acc_src` |
| acc_src | input | XLEN | Register operand |
| acc_imm | input | 5 | Immediate operand, zero-extended |
| csr_addr | input | 12 | Register address |
| cur_priv | input | 2 | Current privilege level |
| csr_present | input | 1 | Addressed register is implemented |
| sup_mode_present | input | 1 | Supervisor mode is built in |
| fp_state | input | 2 | Floating-point state field, 0 = off |
| sup_cnt_en | input | CNT_BITS | Counter enables consulted from user mode |
| mach_cnt_en | input | CNT_BITS | Counter enables consulted from supervisor mode |
| csr_rdata | input | XLEN | Current contents of the addressed register |
| old_value | output | XLEN | Value returned to the destination register |
| wr_data | output | XLEN | Merged value to write back |
| wr_en | output | 1 | Write strobe toward the register storage |
| illegal | output | 1 | Access is rejected |

## Verification
The merge is driven with swap, set and clear operations. Operands and old values are chosen with disjoint and overlapping bit groups, so that a swapped value/mask pair or an inverted mask gives a visibly different result. A zero operand on a set, and a plain read, separate the mask-is-zero rule from the read-only rule. This matters because the same request must be legal on a read-only address and must not write. Each veto source is toggled on its own with the rest held legal, including counter bits taken from the wrong enable word and priority-2 privilege. A long run of mixed requests then weighs every output against a behavioural model.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

    localparam int CSR_ADDR_W = 12;
    localparam int IMM_W      = 5;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_lvl_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_SWAP  = 2'd1,
        ACC_SET   = 2'd2,
        ACC_CLEAR = 2'd3
    } acc_kind_e;

    // one flag per veto source
    typedef struct packed {
        logic absent;
        logic low_priv;
        logic ro_write;
        logic fp_off;
        logic no_super;
        logic cnt_block;
    } veto_t;

    function automatic logic [1:0] addr_min_priv(input logic [CSR_ADDR_W-1:0] a);
        return a[9:8];
    endfunction

    function automatic logic addr_read_only(input logic [CSR_ADDR_W-1:0] a);
        return a[11:10] == 2'b11;
    endfunction

    function automatic logic addr_is_fp(input logic [CSR_ADDR_W-1:0] a);
        return (a >= 12'h001) && (a <= 12'h003);
    endfunction

    function automatic logic addr_is_counter(input logic [CSR_ADDR_W-1:0] a);
        return (a[11:5] == 7'h60) || (a[11:5] == 7'h64);
    endfunction

endpackage

// File: rtl/csr_op_encode.sv
module csr_op_encode
    import csr_gate_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]       kind_i,
    input  logic             use_imm_i,
    input  logic [XLEN-1:0]  src_reg_i,
    input  logic [IMM_W-1:0] src_imm_i,
    output logic [XLEN-1:0]  value_o,
    output logic [XLEN-1:0]  mask_o
);
    localparam int PAD_W = XLEN - IMM_W;

    logic [XLEN-1:0] operand;
    acc_kind_e       kind;

    assign kind    = acc_kind_e'(kind_i);
    assign operand = use_imm_i ? {{PAD_W{1'b0}}, src_imm_i} : src_reg_i;

    always_comb begin
        unique case (kind)
            ACC_SWAP: begin
                value_o = operand;
                mask_o  = '1;
            end
            ACC_SET: begin
                value_o = '1;
                mask_o  = operand;
            end
            ACC_CLEAR: begin
                value_o = '0;
                mask_o  = operand;
            end
            default: begin
                value_o = '0;
                mask_o  = '0;
            end
        endcase
    end
endmodule

// File: rtl/csr_access_gate.sv
module csr_access_gate
    import csr_gate_pkg::*;
#(
    parameter int CNT_BITS = 32
) (
    input  logic [CSR_ADDR_W-1:0] addr_i,
    input  logic [1:0]            priv_i,
    input  logic                  mask_any_i,
    input  logic                  present_i,
    input  logic                  super_present_i,
    input  logic [1:0]            fp_state_i,
    input  logic [CNT_BITS-1:0]   sup_cnt_i,
    input  logic [CNT_BITS-1:0]   mach_cnt_i,
    output veto_t                 veto_o,
    output logic                  illegal_o
);
    localparam int CNT_IDX_W = $clog2(CNT_BITS);

    logic [CNT_IDX_W-1:0] cnt_idx;
    logic                 cnt_allowed;
    priv_lvl_e            priv;

    assign priv    = priv_lvl_e'(priv_i);
    assign cnt_idx = addr_i[CNT_IDX_W-1:0];

    always_comb begin
        unique case (priv)
            PRIV_USER:  cnt_allowed = sup_cnt_i[cnt_idx];
            PRIV_SUPER: cnt_allowed = mach_cnt_i[cnt_idx];
            default:    cnt_allowed = 1'b1;
        endcase
    end

    always_comb begin
        veto_o.absent    = !present_i;
        veto_o.low_priv  = priv_i < addr_min_priv(addr_i);
        veto_o.ro_write  = addr_read_only(addr_i) && mask_any_i;
        veto_o.fp_off    = addr_is_fp(addr_i) && (fp_state_i == 2'b00);
        veto_o.no_super  = (addr_min_priv(addr_i) == 2'b01) && !super_present_i;
        veto_o.cnt_block = addr_is_counter(addr_i) && !cnt_allowed;
    end

    assign illegal_o = |veto_o;
endmodule

// File: rtl/csr_rmw_merge.sv
module csr_rmw_merge #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] value_i,
    input  logic [XLEN-1:0] mask_i,
    input  logic            illegal_i,
    output logic [XLEN-1:0] old_o,
    output logic [XLEN-1:0] wr_data_o,
    output logic            wr_en_o
);
    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        assign wr_data_o[b] = mask_i[b] ? value_i[b] : old_i[b];
        assign old_o[b]     = old_i[b] & !illegal_i;
    end

    assign wr_en_o = (|mask_i) && !illegal_i;
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csr_gate_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CNT_BITS = 32
) (
    input  logic [1:0]            acc_kind,
    input  logic                  acc_use_imm,
    input  logic [XLEN-1:0]       acc_src,
    input  logic [4:0]            acc_imm,
    input  logic [11:0]           csr_addr,
    input  logic [1:0]            cur_priv,
    input  logic                  csr_present,
    input  logic                  sup_mode_present,
    input  logic [1:0]            fp_state,
    input  logic [CNT_BITS-1:0]   sup_cnt_en,
    input  logic [CNT_BITS-1:0]   mach_cnt_en,
    input  logic [XLEN-1:0]       csr_rdata,
    output logic [XLEN-1:0]       old_value,
    output logic [XLEN-1:0]       wr_data,
    output logic                  wr_en,
    output logic                  illegal
);
    logic [XLEN-1:0] enc_value;
    logic [XLEN-1:0] enc_mask;
    veto_t           veto;

    csr_op_encode #(.XLEN(XLEN)) u_encode (
        .kind_i    (acc_kind),
        .use_imm_i (acc_use_imm),
        .src_reg_i (acc_src),
        .src_imm_i (acc_imm),
        .value_o   (enc_value),
        .mask_o    (enc_mask)
    );

    csr_access_gate #(.CNT_BITS(CNT_BITS)) u_gate (
        .addr_i          (csr_addr),
        .priv_i          (cur_priv),
        .mask_any_i      (|enc_mask),
        .present_i       (csr_present),
        .super_present_i (sup_mode_present),
        .fp_state_i      (fp_state),
        .sup_cnt_i       (sup_cnt_en),
        .mach_cnt_i      (mach_cnt_en),
        .veto_o          (veto),
        .illegal_o       (illegal)
    );

    csr_rmw_merge #(.XLEN(XLEN)) u_merge (
        .old_i     (csr_rdata),
        .value_i   (enc_value),
        .mask_i    (enc_mask),
        .illegal_i (illegal),
        .old_o     (old_value),
        .wr_data_o (wr_data),
        .wr_en_o   (wr_en)
    );
endmodule

// File: rtl/csr_access_unit_chk.sv
module csr_access_unit_chk #(
    parameter int XLEN = 32
) (
    input logic [1:0]      acc_kind,
    input logic [11:0]     csr_addr,
    input logic [1:0]      cur_priv,
    input logic            csr_present,
    input logic            sup_mode_present,
    input logic [1:0]      fp_state,
    input logic [XLEN-1:0] csr_rdata,
    input logic [XLEN-1:0] old_value,
    input logic            wr_en,
    input logic            illegal
);
    always_comb begin
        AST_READ_NO_WRITE: assert (acc_kind != 2'd0 || !wr_en)
            else $error("plain read raised a write"); // R3
        AST_PRIV_BLOCK: assert (!(cur_priv < csr_addr[9:8]) || illegal)
            else $error("low privilege accepted"); // R4
        AST_RO_NO_WRITE: assert (!(csr_addr[11:10] == 2'b11 && wr_en))
            else $error("write to read-only address"); // R5
        AST_FP_OFF: assert (!(csr_addr >= 12'h001 && csr_addr <= 12'h003 && fp_state == 2'b00) || illegal)
            else $error("fp register accepted while off"); // R7
        AST_NO_SUPER: assert (!(csr_addr[9:8] == 2'b01 && !sup_mode_present) || illegal)
            else $error("supervisor register accepted without supervisor mode"); // R8
        AST_ABSENT: assert (csr_present || illegal)
            else $error("absent register accepted"); // R9
        AST_ILLEGAL_QUIET: assert (!illegal || (!wr_en && old_value == '0))
            else $error("illegal access leaked"); // R10
        AST_LEGAL_OLD: assert (illegal || old_value == csr_rdata)
            else $error("old value mismatch"); // R11
    end
endmodule

bind csr_access_unit csr_access_unit_chk #(.XLEN(XLEN)) u_chk (
    .acc_kind         (acc_kind),
    .csr_addr         (csr_addr),
    .cur_priv         (cur_priv),
    .csr_present      (csr_present),
    .sup_mode_present (sup_mode_present),
    .fp_state         (fp_state),
    .csr_rdata        (csr_rdata),
    .old_value        (old_value),
    .wr_en            (wr_en),
    .illegal          (illegal)
);

// File: tb/test_csr_access_unit.sv
module test_csr_access_unit;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int CNT_BITS = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   n_checks = 0;
    int   n_errors = 0;

    logic [1:0]          acc_kind = '0;
    logic                acc_use_imm = 1'b0;
    logic [XLEN-1:0]     acc_src = '0;
    logic [4:0]          acc_imm = '0;
    logic [11:0]         csr_addr = '0;
    logic [1:0]          cur_priv = '0;
    logic                csr_present = 1'b0;
    logic                sup_mode_present = 1'b0;
    logic [1:0]          fp_state = '0;
    logic [CNT_BITS-1:0] sup_cnt_en = '0;
    logic [CNT_BITS-1:0] mach_cnt_en = '0;
    logic [XLEN-1:0]     csr_rdata = '0;
    logic [XLEN-1:0]     old_value;
    logic [XLEN-1:0]     wr_data;
    logic                wr_en;
    logic                illegal;

    csr_access_unit #(.XLEN(XLEN), .CNT_BITS(CNT_BITS)) i_csr_access_unit (
        .acc_kind(acc_kind), .acc_use_imm(acc_use_imm), .acc_src(acc_src),
        .acc_imm(acc_imm), .csr_addr(csr_addr), .cur_priv(cur_priv),
        .csr_present(csr_present), .sup_mode_present(sup_mode_present),
        .fp_state(fp_state), .sup_cnt_en(sup_cnt_en), .mach_cnt_en(mach_cnt_en),
        .csr_rdata(csr_rdata), .old_value(old_value), .wr_data(wr_data),
        .wr_en(wr_en), .illegal(illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference, written from the requirement list
    task automatic model(output logic e_ill, output logic e_wen,
                         output logic [XLEN-1:0] e_old, output logic [XLEN-1:0] e_wd);
        logic [XLEN-1:0] opnd, val, msk;
        int need, idx;
        logic bad;
        opnd = acc_use_imm ? XLEN'(acc_imm) : acc_src;          // R1
        case (acc_kind)
            2'd1: begin val = opnd;  msk = '1;   end
            2'd2: begin val = '1;    msk = opnd; end
            2'd3: begin val = '0;    msk = opnd; end
            default: begin val = '0; msk = '0;   end
        endcase
        need = int'(csr_addr) / 256 % 4;
        idx  = int'(csr_addr) % 32;
        bad  = 1'b0;
        if (!csr_present) bad = 1'b1;                                  // R9
        if (int'(cur_priv) < need) bad = 1'b1;                         // R4
        if (csr_addr >= 12'hC00 && msk != 0) bad = 1'b1;               // R5
        if (csr_addr >= 12'h001 && csr_addr <= 12'h003 && fp_state == 0) bad = 1'b1; // R7
        if (need == 1 && !sup_mode_present) bad = 1'b1;                // R8
        if ((csr_addr >= 12'hC00 && csr_addr <= 12'hC1F) ||
            (csr_addr >= 12'hC80 && csr_addr <= 12'hC9F)) begin        // R6
            if (cur_priv == 2'd0 && !sup_cnt_en[idx]) bad = 1'b1;
            if (cur_priv == 2'd1 && !mach_cnt_en[idx]) bad = 1'b1;
        end
        e_ill = bad;
        e_wen = !bad && (msk != 0);                                    // R2 R3 R10
        e_old = bad ? '0 : csr_rdata;                                  // R10 R11
        e_wd  = (csr_rdata & ~msk) | (val & msk);                      // R2
    endtask

    task automatic chk(input string tag, input string what, input logic [XLEN-1:0] got,
                       input logic [XLEN-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic step(input string tag);
        logic e_ill, e_wen;
        logic [XLEN-1:0] e_old, e_wd;
        @(negedge clk);
        model(e_ill, e_wen, e_old, e_wd);
        chk(tag, "illegal", XLEN'(illegal), XLEN'(e_ill));
        chk(tag, "wr_en", XLEN'(wr_en), XLEN'(e_wen));
        chk(tag, "old_value", old_value, e_old);
        if (e_wen) chk(tag, "wr_data", wr_data, e_wd);
    endtask

    task automatic req(input logic [1:0] k, input logic imm_sel, input logic [XLEN-1:0] s,
                       input logic [4:0] im, input logic [11:0] a, input logic [1:0] p,
                       input logic [XLEN-1:0] rd);
        acc_kind = k; acc_use_imm = imm_sel; acc_src = s; acc_imm = im;
        csr_addr = a; cur_priv = p; csr_rdata = rd;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        step("R9_reset");                       // all-zero inputs: absent register
        chk("R10_reset", "wr_en", XLEN'(wr_en), '0);

        csr_present = 1'b1; sup_mode_present = 1'b1; fp_state = 2'd3;
        req(2'd1, 1'b0, 32'hDEADBEEF, 5'd0, 12'h340, 2'd3, 32'h12345678);
        step("R1_R2_R11_swap");
        chk("R2_swap", "wr_data", wr_data, 32'hDEADBEEF);
        req(2'd2, 1'b0, 32'h0000_00F0, 5'd0, 12'h340, 2'd3, 32'h0000_F00F);
        step("R1_R2_set");
        chk("R2_set", "wr_data", wr_data, 32'h0000_F0FF);
        req(2'd3, 1'b0, 32'h0000_000F, 5'd0, 12'h340, 2'd3, 32'h0000_00FF);
        step("R1_R2_clear");
        chk("R2_clear", "wr_data", wr_data, 32'h0000_00F0);
        req(2'd3, 1'b1, 32'hFFFF_0000, 5'h1F, 12'h340, 2'd3, 32'hFFFF_FFFF);
        step("R1_imm_clear");
        chk("R1_imm", "wr_data", wr_data, 32'hFFFF_FFE0);
        req(2'd0, 1'b0, 32'hFFFF_FFFF, 5'd0, 12'h340, 2'd3, 32'hA5A5_A5A5);
        step("R3_read");
        req(2'd2, 1'b0, 32'h0, 5'd0, 12'hF14, 2'd3, 32'h0000_0007);
        step("R3_R5_set_zero_ro");
        chk("R5_ro_read", "illegal", XLEN'(illegal), '0);
        req(2'd1, 1'b0, 32'h1, 5'd0, 12'hF14, 2'd3, 32'h0000_0007);
        step("R5_ro_swap");
        chk("R5_ro_swap", "illegal", XLEN'(illegal), 32'd1);
        req(2'd0, 1'b0, 32'h0, 5'd0, 12'h340, 2'd0, 32'h1111_2222);
        step("R4_user_to_mach");
        req(2'd1, 1'b0, 32'h5, 5'd0, 12'h140, 2'd1, 32'h1111_2222);
        step("R4_super_to_super");
        req(2'd1, 1'b0, 32'h5, 5'd0, 12'h300, 2'd1, 32'h1111_2222);
        step("R4_super_to_mach");

        sup_cnt_en = 32'h0000_0008; mach_cnt_en = 32'h0000_0004;
        req(2'd0, 1'b0, 32'h0, 5'd0, 12'hC02, 2'd0, 32'h0000_0099);
        step("R6_user_bit_clear");
        req(2'd0, 1'b0, 32'h0, 5'd0, 12'hC03, 2'd0, 32'h0000_0099);
        step("R6_user_bit_set");
        req(2'd0, 1'b0, 32'h0, 5'd0, 12'hC02, 2'd1, 32'h0000_0099);
        step("R6_super_bit_set");
        req(2'd0, 1'b0, 32'h0, 5'd0, 12'hC83, 2'd1, 32'h0000_0099);
        step("R6_super_high_clear");
        req(2'd0, 1'b0, 32'h0, 5'd0, 12'hC83, 2'd0, 32'h0000_0099);
        step("R6_user_high_set");
        sup_cnt_en = '0; mach_cnt_en = '0;
        req(2'd0, 1'b0, 32'h0, 5'd0, 12'hC1F, 2'd3, 32'h0000_0099);
        step("R6_mach_always");

        fp_state = 2'd0;
        req(2'd1, 1'b0, 32'h3, 5'd0, 12'h003, 2'd0, 32'h0000_0001);
        step("R7_fp_off");
        req(2'd1, 1'b0, 32'h3, 5'd0, 12'h004, 2'd0, 32'h0000_0001);
        step("R7_non_fp");
        fp_state = 2'd1;
        req(2'd1, 1'b0, 32'h3, 5'd0, 12'h001, 2'd0, 32'h0000_0001);
        step("R7_fp_on");

        sup_mode_present = 1'b0;
        req(2'd1, 1'b0, 32'h3, 5'd0, 12'h105, 2'd3, 32'h0000_0001);
        step("R8_no_super");
        sup_mode_present = 1'b1;
        step("R8_with_super");

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            case (r % 6)
                0: csr_addr = 12'($urandom);
                1: csr_addr = 12'hC00 | 12'($urandom % 32);
                2: csr_addr = 12'hC80 | 12'($urandom % 32);
                3: csr_addr = 12'(1 + $urandom % 3);
                4: csr_addr = 12'h100 | 12'($urandom % 256);
                default: csr_addr = 12'h300 | 12'($urandom % 256);
            endcase
            acc_kind = 2'($urandom); acc_use_imm = 1'($urandom);
            acc_src = ($urandom % 4 == 0) ? '0 : $urandom;
            acc_imm = 5'($urandom); cur_priv = 2'($urandom);
            csr_present = ($urandom % 8 != 0); sup_mode_present = ($urandom % 4 != 0);
            fp_state = 2'($urandom); sup_cnt_en = $urandom; mach_cnt_en = $urandom;
            csr_rdata = $urandom;
            step("RND");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule